// File: doc/BRIEF.md
# I2C Two-Byte Register Read Controller

This block is the only controller on an I2C bus. It fetches one 16-bit register from a target device. The host gives it a 7-bit target address, an 8-bit register index and a one-cycle start request. The controller then runs one fixed combined transaction: a START, the address with the write direction, the index, a repeated START, the address with the read direction, two data bytes and a STOP. At the end it returns the 16-bit value, a one-cycle completion pulse and an error flag.

Both bus lines are open-drain. The block never drives a line high. It pulls SCL or SDA low by asserting the matching output enable, and it reads the resolved SDA level back through `sda_i`.

SCL is made by dividing the system clock. The parameter `QTR_CYC` sets how many system clocks one quarter of an SCL period lasts. A bit slot is four quarters long: two with SCL low, then two with SCL released. The controller moves SDA at the boundary in the middle of the low half. It reads SDA at the boundary in the middle of the high half.

If the target answers any byte the controller sent with NACK, the transaction is cut short with a STOP and reported as an error. The controller makes no retry.

Top module: `i2c_regrd_master`

## Requirements
- R1: When idle, both output enables are low, so the lines are released. A transaction opens with a START: SDA is pulled low while SCL stays released.
- R2: The first byte on the bus is the target address followed by a 0 direction bit. The register index comes next. Every byte is sent most significant bit first. After each byte the controller releases SDA for a ninth clock. A low level in that slot is taken as ACK.
- R3: Once the index is acknowledged, the controller issues a repeated START with no STOP in between. It then sends the address followed by a 1 direction bit.
- R4: The controller reads two bytes, most significant bit first. It answers the first byte with ACK (SDA pulled low) and the second with NACK (SDA released). It then issues a STOP, which releases SDA while SCL is high. `data_o` equals the first byte times 256 plus the second byte.
- R5: If any of the three bytes the controller sent gets a NACK, the next bit slot is a STOP. `err_o` becomes 1, `data_o` becomes 0, and no further START is issued.
- R6: The controller changes SDA only while it holds SCL low. The two exceptions are the SDA fall of a START and the SDA release of a STOP. SCL and SDA never change in the same cycle.
- R7: `done_o` is high for exactly one cycle at the end of every transaction, whether it succeeded or failed. `err_o` and `data_o` change only together with that pulse and hold their values in between.
- R8: A start request that arrives while a transaction is running is ignored. It does not change the result or add a transaction.
- R9: After reset, both enables, `done_o`, `err_o` and `data_o` are 0.
- R10: Each SCL quarter lasts `QTR_CYC` cycles. Let Q stand for `QTR_CYC`. `done_o` rises 192·Q cycles after the start request is accepted for a full read. It rises after 44·Q cycles for a NACK on the write address, 80·Q cycles for a NACK on the index, and 120·Q cycles for a NACK on the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 7 | Target address, captured when a request is accepted |
| reg_i | input | 8 | Register index, captured when a request is accepted |
| data_o | output | 16 | Last read value; 0 after a failed transaction |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| err_o | output | 1 | 1 when the last transaction ended on a NACK |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Resolved SDA line level |

## Verification
Every result is due a fixed number of cycles after the start request is accepted. The completion pulse appears 192, 44, 80 or 120 quarters later, depending on where the transaction ended. The bench counts clock edges from the accepting edge and samples at the falling edge that follows. It checks that the pulse arrives exactly on the expected count and is gone one cycle later.

A clock-accurate target model records the bus events and bytes as they happen: START and STOP conditions, the bytes it received, and the controller's acknowledge bits. These records are compared only after the completion pulse. By then the final STOP has settled, at least one quarter earlier.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_ADW   = 3'd1,
        ST_REG   = 3'd2,
        ST_RST   = 3'd3,
        ST_ADR   = 3'd4,
        ST_MSB   = 3'd5,
        ST_LSB   = 3'd6,
        ST_STOP  = 3'd7
    } step_e;

    typedef struct packed {
        logic        busy;
        step_e       step;
        logic [1:0]  ph;
        logic [3:0]  bitn;
        logic [6:0]  addr;
        logic [7:0]  idx;
        logic [15:0] shreg;
        logic        fail;
        logic        scl_oe;
        logic        sda_oe;
        logic        done;
        logic        err;
        logic [15:0] data;
    } seq_s;

endpackage

// File: rtl/i2c_rr_tick.sv
module i2c_rr_tick #(
    parameter int QTR_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (tick_o)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R10
    AST_TICK_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/i2c_rr_seq.sv
module i2c_rr_seq
    import i2c_rr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        start_i,
    input  logic [6:0]  addr_i,
    input  logic [7:0]  reg_i,
    input  logic        sda_i,
    output logic        busy_o,
    output logic [15:0] data_o,
    output logic        done_o,
    output logic        err_o,
    output logic        scl_oe_o,
    output logic        sda_oe_o
);
    seq_s       d, q;
    step_e      ns;
    logic [3:0] nb;
    logic [1:0] np;
    logic       ent;
    logic [7:0] txb;
    logic       is_tx, is_rx;

    assign is_tx = (q.step == ST_ADW) || (q.step == ST_REG) || (q.step == ST_ADR);
    assign is_rx = (q.step == ST_MSB) || (q.step == ST_LSB);

    always_comb begin
        d   = q;
        d.done = 1'b0;
        ns  = q.step;
        nb  = q.bitn;
        np  = q.ph;
        ent = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.addr  = addr_i;
                d.idx   = reg_i;
                d.fail  = 1'b0;
                d.shreg = '0;
                ns  = ST_START;
                nb  = '0;
                np  = 2'd0;
                ent = 1'b1;
            end
        end else if (tick_i) begin
            np  = q.ph + 2'd1;
            ent = 1'b1;
            if (q.ph == 2'd2) begin
                if (is_tx && q.bitn == 4'd8 && sda_i)
                    d.fail = 1'b1;
                if (is_rx && q.bitn != 4'd8)
                    d.shreg = {q.shreg[14:0], sda_i};
            end
            if (q.ph == 2'd3) begin
                if (q.step == ST_STOP) begin
                    d.busy   = 1'b0;
                    d.done   = 1'b1;
                    d.err    = q.fail;
                    d.data   = q.fail ? 16'h0000 : q.shreg;
                    d.scl_oe = 1'b0;
                    d.sda_oe = 1'b0;
                    ent      = 1'b0;
                end else if (q.step == ST_START || q.step == ST_RST) begin
                    ns = step_e'(q.step + 3'd1);
                    nb = '0;
                end else if (q.bitn != 4'd8) begin
                    nb = q.bitn + 4'd1;
                end else if (is_tx && q.fail) begin
                    ns = ST_STOP;
                    nb = '0;
                end else begin
                    ns = step_e'(q.step + 3'd1);
                    nb = '0;
                end
            end
        end

        case (ns)
            ST_ADW:  txb = {q.addr, 1'b0};
            ST_ADR:  txb = {q.addr, 1'b1};
            default: txb = q.idx;
        endcase

        if (ent) begin
            d.step = ns;
            d.bitn = nb;
            d.ph   = np;
            case (ns)
                ST_START, ST_RST: begin
                    d.scl_oe = (np == 2'd0) && (ns == ST_RST);
                    d.sda_oe = np[1];
                end
                ST_STOP: begin
                    d.scl_oe = !np[1];
                    if (np == 2'd1)
                        d.sda_oe = 1'b1;
                    else if (np == 2'd3)
                        d.sda_oe = 1'b0;
                end
                ST_MSB, ST_LSB: begin
                    d.scl_oe = !np[1];
                    if (np == 2'd1)
                        d.sda_oe = (nb == 4'd8) && (ns == ST_MSB);
                end
                default: begin
                    d.scl_oe = !np[1];
                    if (np == 2'd1)
                        d.sda_oe = (nb == 4'd8) ? 1'b0 : !txb[3'd7 - nb[2:0]];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, step: ST_START, ph: 2'd0, bitn: 4'd0,
                   addr: 7'd0, idx: 8'd0, shreg: 16'd0, fail: 1'b0,
                   scl_oe: 1'b0, sda_oe: 1'b0, done: 1'b0, err: 1'b0,
                   data: 16'd0};
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign data_o   = q.data;
    assign done_o   = q.done;
    assign err_o    = q.err;
    assign scl_oe_o = q.scl_oe;
    assign sda_oe_o = q.sda_oe;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (!q.scl_oe && !q.sda_oe)); // R9
    AST_START_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.scl_oe && !$past(q.scl_oe) && q.sda_oe && !$past(q.sda_oe))
        |-> (q.step == ST_START || q.step == ST_RST)); // R1
    AST_STOP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.scl_oe && !$past(q.scl_oe) && !q.sda_oe && $past(q.sda_oe))
        |-> (q.step == ST_STOP)); // R4
    AST_NO_DUAL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.scl_oe) |-> $stable(q.sda_oe)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> ($stable(q.data) && $stable(q.err))); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start_i) |=> ($stable(q.addr) && $stable(q.idx))); // R8
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.bitn <= 4'd8); // R2

endmodule

// File: rtl/i2c_regrd_master.sv
module i2c_regrd_master #(
    parameter int QTR_CYC = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [6:0]  addr_i,
    input  logic [7:0]  reg_i,
    output logic [15:0] data_o,
    output logic        done_o,
    output logic        err_o,
    output logic        scl_oe_o,
    output logic        sda_oe_o,
    input  logic        sda_i
);
    logic busy;
    logic tick;

    i2c_rr_tick #(.QTR_CYC(QTR_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy),
        .tick_o (tick)
    );

    i2c_rr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .start_i  (start_i),
        .addr_i   (addr_i),
        .reg_i    (reg_i),
        .sda_i    (sda_i),
        .busy_o   (busy),
        .data_o   (data_o),
        .done_o   (done_o),
        .err_o    (err_o),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o)
    );

endmodule

// File: tb/i2c_regrd_master_tb.sv
module i2c_regrd_master_tb;
    localparam int Q = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start_i = 1'b0;
    logic [6:0]  addr_i = '0;
    logic [7:0]  reg_i = '0;
    logic [15:0] data_o;
    logic        done_o, err_o, scl_oe_o, sda_oe_o;
    logic        t_oe = 1'b0;

    wire scl_w = !scl_oe_o;
    wire sda_w = !(sda_oe_o | t_oe);

    i2c_regrd_master #(.QTR_CYC(Q)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .addr_i   (addr_i),
        .reg_i    (reg_i),
        .data_o   (data_o),
        .done_o   (done_o),
        .err_o    (err_o),
        .scl_oe_o (scl_oe_o),
        .sda_oe_o (sda_oe_o),
        .sda_i    (sda_w)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // target model and bus monitor state
    logic [6:0]  t_addr = '0;
    bit          nack_reg = 0, nack_rd = 0;
    int          t_mode = 0, t_cnt = 0, t_bi = 0;
    logic [7:0]  t_sh = '0, t_reg = '0;
    logic [15:0] t_word = '0;
    bit          t_acc = 0;
    logic        tp_scl = 1'b1, tp_sda = 1'b1;
    logic        pm_scl = 1'b0, pm_sda = 1'b0;
    int          n_start = 0, n_stop = 0, nlog = 0, n_dual = 0, n_hichg = 0, n_done = 0;
    logic [7:0]  blog [0:3];
    logic        mlog [0:1];

    function automatic logic [15:0] exp_word(input logic [6:0] a, input logic [7:0] r);
        logic [7:0] hi, lo;
        hi = r ^ 8'h5C;
        lo = r + {1'b0, a};
        return {hi, lo};
    endfunction

    always @(negedge clk) begin
        logic sc, sd;
        sc = scl_w;
        sd = sda_w;
        if (done_o) n_done++;
        if (scl_oe_o != pm_scl && sda_oe_o != pm_sda) n_dual++;
        if (!scl_oe_o && !pm_scl && sda_oe_o != pm_sda) n_hichg++;
        pm_scl = scl_oe_o;
        pm_sda = sda_oe_o;
        if (tp_scl && sc && tp_sda && !sd) begin
            n_start++; t_mode = 1; t_cnt = 0; t_oe = 1'b0;
        end else if (tp_scl && sc && !tp_sda && sd) begin
            n_stop++; t_mode = 0; t_oe = 1'b0;
        end else if (!tp_scl && sc) begin
            if (t_mode == 1 || t_mode == 2) begin
                if (t_cnt < 8) begin t_sh = {t_sh[6:0], sd}; t_cnt++; end
                else t_cnt = 9;
            end else if (t_mode == 3) begin
                if (t_cnt < 8) t_cnt++;
                else begin mlog[t_bi] = sd; t_cnt = 9; end
            end
        end else if (tp_scl && !sc) begin
            if (t_mode == 1 || t_mode == 2) begin
                if (t_cnt == 8) begin
                    if (nlog < 4) blog[nlog] = t_sh;
                    nlog++;
                    if (t_mode == 1) t_acc = (t_sh[7:1] == t_addr) && !(t_sh[0] && nack_rd);
                    else begin t_acc = !nack_reg; t_reg = t_sh; end
                    t_oe = t_acc;
                end else if (t_cnt == 9) begin
                    t_oe = 1'b0; t_cnt = 0;
                    if (!t_acc || t_mode == 2) t_mode = 0;
                    else if (t_sh[0]) begin
                        t_mode = 3; t_bi = 0;
                        t_word = exp_word(t_addr, t_reg);
                        t_oe = !t_word[15];
                    end else t_mode = 2;
                end
            end else if (t_mode == 3) begin
                if (t_cnt < 8) t_oe = !t_word[(t_bi != 0) ? (7 - t_cnt) : (15 - t_cnt)];
                else if (t_cnt == 8) t_oe = 1'b0;
                else if (!mlog[t_bi] && t_bi == 0) begin
                    t_bi = 1; t_cnt = 0; t_oe = !t_word[7];
                end else begin
                    t_mode = 0; t_oe = 1'b0;
                end
            end
        end
        tp_scl = sc;
        tp_sda = sd;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // kind: 0 full read, 1 wrong address, 2 index NACK, 3 read-address NACK
    task automatic run(input logic [6:0] a, input logic [7:0] r, input int kind, input bit poke);
        int k, lat, ex_starts, ex_nlog, pd;
        logic [15:0] d0;
        logic e0;
        @(negedge clk);
        t_addr   = (kind == 1) ? ~a : a;
        nack_reg = (kind == 2);
        nack_rd  = (kind == 3);
        n_start = 0; n_stop = 0; nlog = 0; n_dual = 0; n_hichg = 0;
        mlog[0] = 1'bx; mlog[1] = 1'bx;
        pd = n_done;
        start_i = 1'b1; addr_i = a; reg_i = r;
        @(posedge clk);
        k = 0;
        forever begin
            @(negedge clk);
            if (k == 0) start_i = 1'b0;
            if (poke && k == 50) begin start_i = 1'b1; addr_i = ~a; reg_i = ~r; end
            if (poke && k == 51) start_i = 1'b0;
            if (done_o || k > 5000) break;
            @(posedge clk);
            k++;
        end
        case (kind)
            0: lat = 192 * Q;
            1: lat = 44 * Q;
            2: lat = 80 * Q;
            default: lat = 120 * Q;
        endcase
        ex_starts = (kind == 1 || kind == 2) ? 1 : 2;
        ex_nlog   = (kind == 0 || kind == 3) ? 3 : kind;
        chk(k == lat, "R10 done latency", k, lat);
        chk(err_o == (kind != 0), "R5 error flag", err_o, kind != 0);
        chk(data_o == ((kind == 0) ? exp_word(a, r) : 16'h0), "R4 read data", data_o,
            (kind == 0) ? exp_word(a, r) : 16'h0);
        chk(n_start == ex_starts, "R1 START count", n_start, ex_starts);
        chk(n_stop == 1, "R5 STOP count", n_stop, 1);
        chk(nlog == ex_nlog, "R2 bytes seen by target", nlog, ex_nlog);
        chk(blog[0] == {a, 1'b0}, "R2 write address byte", blog[0], {a, 1'b0});
        if (kind == 0 || kind == 2)
            chk(blog[1] == r, "R2 index byte", blog[1], r);
        if (kind == 0 || kind == 3)
            chk(blog[2] == {a, 1'b1}, "R3 read address byte", blog[2], {a, 1'b1});
        if (kind == 0) begin
            chk(mlog[0] === 1'b0, "R4 ACK after first byte", mlog[0], 0);
            chk(mlog[1] === 1'b1, "R4 NACK after second byte", mlog[1], 1);
        end
        chk(n_dual == 0, "R6 SCL and SDA same-cycle change", n_dual, 0);
        chk(n_hichg == ex_starts + 1, "R6 SDA changes with SCL high", n_hichg, ex_starts + 1);
        d0 = data_o; e0 = err_o;
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        chk(data_o == d0 && err_o == e0, "R7 result held", {err_o, data_o}, {e0, d0});
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(n_done == pd + 1, "R8 single completion", n_done, pd + 1);
            chk(scl_oe_o == 1'b0 && sda_oe_o == 1'b0, "R8 bus idle after ignored start",
                {scl_oe_o, sda_oe_o}, 0);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(scl_oe_o == 0 && sda_oe_o == 0, "R9 reset enables", {scl_oe_o, sda_oe_o}, 0);
        chk(done_o == 0 && err_o == 0, "R9 reset flags", {done_o, err_o}, 0);
        chk(data_o == 0, "R9 reset data", data_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_oe_o == 0 && sda_oe_o == 0, "R1 idle released", {scl_oe_o, sda_oe_o}, 0);
        for (int ai = 0; ai < 4; ai++) begin
            for (int r = 0; r < 256; r += 17) begin
                logic [6:0] a;
                case (ai)
                    0: a = 7'h00;
                    1: a = 7'h2A;
                    2: a = 7'h50;
                    default: a = 7'h7F;
                endcase
                run(a, 8'(r), 0, 0);
            end
        end
        for (int kind = 1; kind < 4; kind++) begin
            run(7'h13, 8'h3C, kind, 0);
            run(7'h6E, 8'hC1, kind, 0);
        end
        run(7'h21, 8'h7E, 0, 0);
        run(7'h35, 8'h81, 0, 1);
        run(7'h35, 8'h81, 1, 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule